// File: doc/BRIEF.md
# Coherent Dual-Word Parameter RAM

This block is a small parameter store built from 16-bit words. Two clients share it. A host reaches it through a 16-bit word port that also carries a long-word strobe. A channel engine reaches it through a 32-bit port that always moves one whole pair of adjacent words. A 32-bit quantity lives in one such pair. The even word holds the upper half and the odd word holds the lower half.

When the host marks two consecutive word accesses as one long-word access, the block makes them indivisible. On a long-word write, the upper half is parked in a holding register, and both words land in storage on the same clock edge when the lower half arrives. On a long-word read, the lower half is captured at the moment the upper half is read. The second read is then served from that capture. Plain word accesses carry no such guarantee. The same applies to a long-word access that starts on an odd word address.

Top module: `coherent_param_ram`

## Requirements
- R1: After reset, `h_rdata` and `e_rdata` are zero, no long-word write is pending and no long-word read capture is held. A long-word write to an odd address then acts as a plain word write.
- R2: A host access with `h_long` low writes or reads exactly the word at `h_addr`. Read data appears on `h_rdata` one cycle later. Word 2p is bits 31:16 and word 2p+1 is bits 15:0 of engine pair p.
- R3: A host long-word write to an even address leaves storage unchanged and only opens a pending pair at `h_addr/2`.
- R4: A host long-word write to the odd address of the pending pair writes the held upper half and the new lower half on the same edge, and closes the pending pair.
- R5: A host long-word read of an even address returns that word and captures the odd word of the same instant. A following long-word read of that odd address returns the captured value, whatever was written in between.
- R6: A long-word access to an odd address that does not close a matching pending pair is performed as a plain word access, and any pending pair stays open.
- R7: An engine write stores both halves of pair `e_pair` on one edge. An engine read returns both halves as of one instant, one cycle later on `e_rdata`.
- R8: When host and engine write the same word in one cycle, the host value is kept. Reads in a cycle return the contents from before that cycle's writes.
- R9: An engine write to a pair between the two halves of a host long-word write to that pair is wholly replaced by the host value.
- R10: `h_rdata` holds its value in any cycle without a host read, and `e_rdata` holds its value in any cycle without an engine read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host access this cycle |
| h_we | input | 1 | Host write (1) or read (0) |
| h_long | input | 1 | Host access is half of a long-word access |
| h_addr | input | AW | Host word address |
| h_wdata | input | W | Host write word |
| h_rdata | output | W | Host read word, registered |
| e_sel | input | 1 | Engine access this cycle |
| e_we | input | 1 | Engine write (1) or read (0) |
| e_pair | input | AW-1 | Engine pair index |
| e_wdata | input | 2W | Engine write pair, upper half is the even word |
| e_rdata | output | 2W | Engine read pair, registered |

## Verification
Suppose the write-holding register loses or gains its pending state. The next engine read of that pair then shows one half new and one half old, and this becomes visible one cycle after the closing host write. A stale or missing read capture shows up as a wrong lower half on `h_rdata` in the cycle after the closing long-word read. A wrong collision rule between host and engine shows up as a word that disagrees with the model on the first later read of it. The bench compares both read ports against the reference model on every clock edge.

// File: rtl/cprm_pkg.sv
package cprm_pkg;
  typedef enum logic [2:0] {
    HK_IDLE,
    HK_READ,
    HK_WRITE,
    HK_LWR_OPEN,
    HK_LWR_CLOSE,
    HK_LRD_OPEN,
    HK_LRD_CLOSE
  } hkind_e;
endpackage

// File: rtl/cprm_host_dec.sv
module cprm_host_dec
  import cprm_pkg::*;
(
  input  logic   sel,
  input  logic   we,
  input  logic   lng,
  input  logic   odd,
  input  logic   hold_hit,
  input  logic   cap_hit,
  output hkind_e kind
);
  always_comb begin
    kind = HK_IDLE;
    if (sel) begin
      if (we) begin
        if (lng && !odd)             kind = HK_LWR_OPEN;
        else if (lng && hold_hit)    kind = HK_LWR_CLOSE;
        else                         kind = HK_WRITE;
      end else begin
        if (lng && !odd)             kind = HK_LRD_OPEN;
        else if (lng && cap_hit)     kind = HK_LRD_CLOSE;
        else                         kind = HK_READ;
      end
    end
  end
endmodule

// File: rtl/cprm_half_reg.sv
module cprm_half_reg #(
  parameter int PW = 5,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic [PW-1:0] pair_in,
  input  logic [W-1:0]  data_in,
  output logic          vld,
  output logic [PW-1:0] pair,
  output logic [W-1:0]  data
);
  logic vld_d;

  always_comb begin
    vld_d = vld;
    if (load)       vld_d = 1'b1;
    else if (clear) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      pair <= pair_in;
      data <= data_in;
    end
  end
endmodule

// File: rtl/cprm_bank.sv
module cprm_bank #(
  parameter int PW = 5,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [PW-1:0] a_addr,
  input  logic [W-1:0]  a_d,
  input  logic          b_we,
  input  logic [PW-1:0] b_addr,
  input  logic [W-1:0]  b_d,
  input  logic [PW-1:0] r0_addr,
  output logic [W-1:0]  r0_q,
  input  logic [PW-1:0] r1_addr,
  output logic [W-1:0]  r1_q
);
  localparam int DEPTH = 1 << PW;
  logic [W-1:0] mem [DEPTH];

  // port b is applied last, so it wins on an address clash
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_d;
    if (b_we) mem[b_addr] <= b_d;
  end

  assign r0_q = mem[r0_addr];
  assign r1_q = mem[r1_addr];
endmodule

// File: rtl/coherent_param_ram.sv
module coherent_param_ram
  import cprm_pkg::*;
#(
  parameter int AW = 6,
  parameter int W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            h_sel,
  input  logic            h_we,
  input  logic            h_long,
  input  logic [AW-1:0]   h_addr,
  input  logic [W-1:0]    h_wdata,
  output logic [W-1:0]    h_rdata,
  input  logic            e_sel,
  input  logic            e_we,
  input  logic [AW-2:0]   e_pair,
  input  logic [2*W-1:0]  e_wdata,
  output logic [2*W-1:0]  e_rdata
);
  localparam int PW = AW - 1;

  logic          rst_s1, rst_ni;
  logic [PW-1:0] h_pair;
  hkind_e        kind;
  logic          hold_vld, cap_vld;
  logic [PW-1:0] hold_pair, cap_pair;
  logic [W-1:0]  hold_data, cap_data;
  logic          hw_en   [2];
  logic [W-1:0]  hw_data [2];
  logic [W-1:0]  e_half  [2];
  logic [W-1:0]  h_rd    [2];
  logic [W-1:0]  e_rd    [2];
  logic [W-1:0]  h_rdata_d;
  logic [2*W-1:0] e_rdata_d;
  logic          e_wr, e_rd_en;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ni <= rst_s1;
    end
  end

  assign h_pair  = h_addr[AW-1:1];
  assign e_wr    = e_sel && e_we;
  assign e_rd_en = e_sel && !e_we;
  assign e_half[0] = e_wdata[2*W-1:W];
  assign e_half[1] = e_wdata[W-1:0];

  cprm_host_dec u_dec (
    .sel      (h_sel),
    .we       (h_we),
    .lng      (h_long),
    .odd      (h_addr[0]),
    .hold_hit (hold_vld && (hold_pair == h_pair)),
    .cap_hit  (cap_vld && (cap_pair == h_pair)),
    .kind     (kind)
  );

  cprm_half_reg #(.PW(PW), .W(W)) u_whold (
    .clk     (clk),
    .rst_n   (rst_ni),
    .load    (kind == HK_LWR_OPEN),
    .clear   (kind == HK_LWR_CLOSE),
    .pair_in (h_pair),
    .data_in (h_wdata),
    .vld     (hold_vld),
    .pair    (hold_pair),
    .data    (hold_data)
  );

  cprm_half_reg #(.PW(PW), .W(W)) u_rcap (
    .clk     (clk),
    .rst_n   (rst_ni),
    .load    (kind == HK_LRD_OPEN),
    .clear   (kind == HK_LRD_CLOSE),
    .pair_in (h_pair),
    .data_in (h_rd[1]),
    .vld     (cap_vld),
    .pair    (cap_pair),
    .data    (cap_data)
  );

  // host write steering: bank 0 holds even words, bank 1 odd words
  always_comb begin
    for (int b = 0; b < 2; b++) begin
      hw_en[b]   = 1'b0;
      hw_data[b] = h_wdata;
    end
    case (kind)
      HK_WRITE: hw_en[h_addr[0]] = 1'b1;
      HK_LWR_CLOSE: begin
        hw_en[0]   = 1'b1;
        hw_en[1]   = 1'b1;
        hw_data[0] = hold_data;
      end
      default: ;
    endcase
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    cprm_bank #(.PW(PW), .W(W)) u_bank (
      .clk     (clk),
      .a_we    (e_wr),
      .a_addr  (e_pair),
      .a_d     (e_half[b]),
      .b_we    (hw_en[b]),
      .b_addr  (h_pair),
      .b_d     (hw_data[b]),
      .r0_addr (h_pair),
      .r0_q    (h_rd[b]),
      .r1_addr (e_pair),
      .r1_q    (e_rd[b])
    );
  end

  always_comb begin
    case (kind)
      HK_READ:      h_rdata_d = h_rd[h_addr[0]];
      HK_LRD_OPEN:  h_rdata_d = h_rd[0];
      HK_LRD_CLOSE: h_rdata_d = cap_data;
      default:      h_rdata_d = h_rdata;
    endcase
    e_rdata_d = e_rd_en ? {e_rd[0], e_rd[1]} : e_rdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      h_rdata <= '0;
      e_rdata <= '0;
    end else begin
      h_rdata <= h_rdata_d;
      e_rdata <= e_rdata_d;
    end
  end
endmodule

// File: rtl/cprm_chk.sv
module cprm_chk #(
  parameter int AW = 6,
  parameter int W  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           h_sel,
  input logic           h_we,
  input logic           h_long,
  input logic [AW-1:0]  h_addr,
  input logic [W-1:0]   h_rdata,
  input logic           e_sel,
  input logic           e_we,
  input logic [2*W-1:0] e_rdata,
  input logic           hold_vld,
  input logic [AW-2:0]  hold_pair,
  input logic           cap_vld
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (h_rdata == '0 && e_rdata == '0 && !hold_vld && !cap_vld)); // R1

  AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && h_we && h_long && !h_addr[0]) |=> hold_vld); // R3

  AST_HOLD_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && h_we && h_long && h_addr[0] && hold_vld && h_addr[AW-1:1] == hold_pair)
    |=> !hold_vld); // R4

  AST_CAP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && !h_we && h_long && !h_addr[0]) |=> cap_vld); // R5

  AST_HRD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_sel && !h_we) |=> $stable(h_rdata)); // R10

  AST_ERD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(e_sel && !e_we) |=> $stable(e_rdata)); // R10
endmodule

bind coherent_param_ram cprm_chk #(.AW(AW), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .h_sel     (h_sel),
  .h_we      (h_we),
  .h_long    (h_long),
  .h_addr    (h_addr),
  .h_rdata   (h_rdata),
  .e_sel     (e_sel),
  .e_we      (e_we),
  .e_rdata   (e_rdata),
  .hold_vld  (hold_vld),
  .hold_pair (hold_pair),
  .cap_vld   (cap_vld)
);

// File: tb/tb_coherent_param_ram.sv
module tb_coherent_param_ram;
  localparam int AW = 6;
  localparam int W  = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk, rst_n;
  logic          h_sel, h_we, h_long;
  logic [AW-1:0] h_addr;
  logic [W-1:0]  h_wdata, h_rdata;
  logic          e_sel, e_we;
  logic [AW-2:0] e_pair;
  logic [31:0]   e_wdata, e_rdata;

  coherent_param_ram #(.AW(AW), .W(W)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // reference model
  logic [15:0] m_mem [DEPTH];
  logic        m_hold_v, m_cap_v;
  int          m_hold_p, m_cap_p;
  logic [15:0] m_hold_d, m_cap_d;
  logic [15:0] m_h;
  logic [31:0] m_e;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic hs, input logic hw, input logic hl, input int ha,
                      input logic [15:0] hd, input logic es, input logic ew,
                      input int ep, input logic [31:0] ed, input string tag);
    @(negedge clk);
    h_sel = hs; h_we = hw; h_long = hl; h_addr = AW'(ha); h_wdata = hd;
    e_sel = es; e_we = ew; e_pair = (AW-1)'(ep); e_wdata = ed;
    @(posedge clk);
    ha = ha % DEPTH;
    ep = ep % (DEPTH / 2);
    if (hs && !hw) begin
      if (hl && ha % 2 == 0) begin
        m_h = m_mem[ha]; m_cap_d = m_mem[ha + 1]; m_cap_v = 1'b1; m_cap_p = ha / 2;
      end else if (hl && m_cap_v && m_cap_p == ha / 2) begin
        m_h = m_cap_d; m_cap_v = 1'b0;
      end else m_h = m_mem[ha];
    end
    if (es && !ew) m_e = {m_mem[2*ep], m_mem[2*ep + 1]};
    if (es && ew) begin
      m_mem[2*ep] = ed[31:16]; m_mem[2*ep + 1] = ed[15:0];
    end
    if (hs && hw) begin
      if (hl && ha % 2 == 0) begin
        m_hold_d = hd; m_hold_v = 1'b1; m_hold_p = ha / 2;
      end else if (hl && m_hold_v && m_hold_p == ha / 2) begin
        m_mem[ha - 1] = m_hold_d; m_mem[ha] = hd; m_hold_v = 1'b0;
      end else m_mem[ha] = hd;
    end
    #1;
    chk(tag, 32'(h_rdata), 32'(m_h));
    chk(tag, e_rdata, m_e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic hwr(input logic hl, input int a, input logic [15:0] d, input string tag);
    step(1, 1, hl, a, d, 0, 0, 0, 0, tag);
  endtask
  task automatic hrd(input logic hl, input int a, input string tag);
    step(1, 0, hl, a, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic ewr(input int p, input logic [31:0] d, input string tag);
    step(0, 0, 0, 0, 0, 1, 1, p, d, tag);
  endtask
  task automatic erd(input int p, input string tag);
    step(0, 0, 0, 0, 0, 1, 0, p, 0, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    h_sel = 0; h_we = 0; h_long = 0; h_addr = '0; h_wdata = '0;
    e_sel = 0; e_we = 0; e_pair = '0; e_wdata = '0;
    m_hold_v = 0; m_cap_v = 0; m_hold_p = 0; m_cap_p = 0;
    m_hold_d = 0; m_cap_d = 0; m_h = 0; m_e = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    idle("R1");                                   // reset values
    for (int p = 0; p < DEPTH / 2; p++) ewr(p, {16'hA000 + 16'(p), 16'h5000 + 16'(p)}, "R7");
    erd(3, "R7"); erd(31, "R7");

    // R1: no pending pair after reset, odd long write is a plain write
    hwr(1, 7, 16'h7777, "R1"); hrd(0, 7, "R1"); hrd(0, 6, "R1"); erd(3, "R1");

    // R2: plain word access, even word is upper half
    hwr(0, 4, 16'h1234, "R2"); hrd(0, 4, "R2"); erd(2, "R2"); hrd(0, 5, "R2");

    // R3/R4/R9: long write with engine write between the halves
    hwr(1, 8, 16'hBEEF, "R3"); erd(4, "R3");
    ewr(4, 32'h1111_2222, "R9"); erd(4, "R9");
    hwr(1, 9, 16'hCAFE, "R4"); erd(4, "R4"); erd(4, "R9");

    // R5: long read with engine write in between
    hrd(1, 10, "R5");
    ewr(5, 32'h3333_4444, "R5");
    hrd(1, 11, "R5"); hrd(0, 11, "R5"); hrd(0, 10, "R5");

    // R6: odd long write not matching pending pair
    hwr(1, 16, 16'h0F0F, "R6");
    hwr(1, 13, 16'h1313, "R6"); hrd(0, 13, "R6"); erd(8, "R6");
    hwr(1, 17, 16'hF0F0, "R6"); erd(8, "R4");
    hrd(1, 19, "R6");

    // R8: same-cycle host and engine writes, reads before writes
    step(1, 1, 0, 20, 16'hDDDD, 1, 1, 10, 32'h9999_8888, "R8");
    hrd(0, 20, "R8"); hrd(0, 21, "R8");
    hwr(1, 22, 16'h2222, "R8");
    step(1, 1, 1, 23, 16'h2323, 1, 0, 11, 0, "R8");
    erd(11, "R8");
    step(1, 1, 1, 24, 16'hAAAA, 1, 1, 12, 32'h5555_6666, "R8");
    step(1, 1, 1, 25, 16'hBBBB, 1, 1, 12, 32'h7777_8888, "R8");
    erd(12, "R8");
    step(1, 0, 0, 25, 0, 1, 1, 12, 32'h0102_0304, "R8");

    // R10: outputs hold without reads
    idle("R10"); hwr(0, 30, 16'h3030, "R10"); ewr(0, 32'h0, "R10"); idle("R10");

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[2] | r[3], int'(r[9:4]) , 16'($urandom),
           r[10], r[11], int'(r[16:12]), $urandom, "R2");
    end
    idle("R10");
    finish_run();
  end
endmodule